// File: doc/BRIEF.md
# Split-Latency Integer Execution Unit with Condition Flags

This block is the integer execution unit of an in-order, fine-grained multithreaded pipeline. Each cycle it may accept one operation carrying two 32-bit operands, a 4-bit operation code, the issuing thread's carry condition bit, that thread's Y register and a thread tag. Add, subtract, the bitwise operations and an immediate pass-through retire one cycle after issue. Shifts and 32x32 multiplies go down a separate, fully pipelined path and retire two cycles after issue. The same adder serves plain arithmetic and the address work that the pipeline sends through it: load/store addresses, jump and call targets, and register-window adds and subtracts. Reads of status and window-mask registers use the pass and XOR operations.

Every retiring operation presents its result, its thread tag, the negative, zero, overflow and carry flags, and a Y value. A multiply places the upper half of its 64-bit product on the Y output and raises a Y write strobe. Any other operation returns the Y value it was issued with, unchanged. Because the two paths have different latencies, a single-cycle operation issued in the cycle right after a two-cycle operation would retire in the same cycle as that operation. The unit reports that collision on a combinational issue-check output, and the issue logic upstream must hold the operation back. If the operation is presented anyway, the unit drops it and retires only the two-cycle operation.

Top module: `split_alu`

## Requirements
- R1: Operation codes: 0 ADD, 1 ADDX, 2 SUB, 3 SUBX, 4 AND, 5 OR, 6 XOR, 7 ANDN, 8 ORN, 9 XNOR, 10 PASS, 11 SLL, 12 SRL, 13 SRA, 14 UMUL, 15 SMUL. Codes 0 to 10 retire with out_valid high and the issuing in_tid on out_tid one clock after issue. ADD gives a+b, ADDX a+b+in_cin, SUB a-b and SUBX a-b-in_cin, each modulo 2^32.
- R2: For ADD and ADDX, out_c is the carry out of bit 31, and out_v is set when both operands have the same sign and the result sign differs from it.
- R3: For SUB, out_c is set when a < b unsigned. For SUBX, out_c is set when a < b+in_cin, taken unsigned and 33 bits wide. For both, out_v is set when the operand signs differ and the result sign differs from the sign of a.
- R4: AND gives a&b, OR a|b, XOR a^b, ANDN a&~b, ORN a|~b and XNOR ~(a^b). All have out_v=out_c=0.
- R5: PASS returns b[21:0] in bits 31:10 and zero in bits 9:0. It ignores in_a and b[31:22] and has out_v=out_c=0.
- R6: For every retiring operation, out_n equals result bit 31 and out_z is set exactly when the 32-bit result is zero.
- R7: SLL, SRL (zero fill) and SRA (sign fill) shift a by b[4:0]. Bits 31:5 of b are ignored. The result retires two clocks after issue with out_v=out_c=0.
- R8: UMUL and SMUL (unsigned and two's-complement) put the low 32 bits of the 64-bit product on out_result and the high 32 bits on out_y, with out_y_wr=1. They retire two clocks after issue, with N and Z taken from the low word and out_v=out_c=0.
- R9: Every operation other than a multiply retires with out_y_wr=0 and out_y equal to the in_y it was issued with.
- R10: Shifts and multiplies accept a new operation every cycle. Each one retires two clocks after its issue, in issue order, with its own tag.
- R11: issue_conflict is high in the same cycle when a valid operation with code 0 to 10 is presented one clock after a code 11 to 15 issue. That single-cycle operation is then dropped, and the following cycle shows only the two-cycle operation's retirement.
- R12: out_valid is low during and after reset until something retires. It is low in any cycle that follows a cycle with no issue and no two-cycle operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is issued this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand, shift amount or immediate |
| in_cin | input | 1 | Thread carry bit for ADDX/SUBX |
| in_y | input | 32 | Thread Y register value |
| in_tid | input | 6 | Thread tag |
| issue_conflict | output | 1 | Single-cycle op would collide with a two-cycle retirement |
| out_valid | output | 1 | A result retires this cycle |
| out_tid | output | 6 | Tag of the retiring operation |
| out_result | output | 32 | Result (low product word for multiplies) |
| out_y | output | 32 | New Y value for the retiring thread |
| out_y_wr | output | 1 | Y is written (multiply) |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry / borrow flag |

## Verification
A wrong carry-in polarity or a wrong overflow term in the shared adder shows up one clock after issue, as a wrong out_c or out_v on the boundary operands (all-ones plus one, the largest positive plus one, equal operands with a borrow in). A bad partial product or a missing sign correction in the two-cycle multiply shows up two clocks after issue, mostly in out_y, which is why the product high word is checked on every multiply. A stage-one register that takes the wrong tag, or a retire mux with the wrong priority, shows up as a mismatched out_tid or a missing retirement on back-to-back and colliding issues. The bench therefore mixes random traffic with forced long-then-short sequences.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDX = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBX = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_ANDN = 4'd7,
      OP_ORN  = 4'd8,
      OP_XNOR = 4'd9,
      OP_PASS = 4'd10,
      OP_SLL  = 4'd11,
      OP_SRL  = 4'd12,
      OP_SRA  = 4'd13,
      OP_UMUL = 4'd14,
      OP_SMUL = 4'd15
   } alu_op_e;

   // Two-cycle class: shifts and multiplies occupy the top of the code space
   function automatic logic op_is_long(input logic [3:0] op);
      return op >= OP_SLL;
   endfunction

   function automatic logic op_is_arith(input logic [3:0] op);
      return op <= OP_SUBX;
   endfunction

   function automatic logic op_is_mul(input logic [3:0] op);
      return (op == OP_UMUL) || (op == OP_SMUL);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
   import alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   op,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         flag_v,
   output logic         flag_c
);

   logic         is_sub;
   logic         use_cin;
   logic [W-1:0] b_eff;
   logic         c_eff;
   logic [W:0]   wide;

   always_comb begin
      is_sub  = (op == OP_SUB) || (op == OP_SUBX);
      use_cin = (op == OP_ADDX) || (op == OP_SUBX);
      b_eff   = is_sub ? ~b : b;
      // subtract: a + ~b + 1 (plain) or a + ~b + ~cin (with borrow in)
      if (is_sub) c_eff = use_cin ? ~cin : 1'b1;
      else        c_eff = use_cin ? cin : 1'b0;
      wide   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
      sum    = wide[W-1:0];
      flag_c = is_sub ? ~wide[W] : wide[W];
      if (is_sub) flag_v = (a[W-1] ^ b[W-1]) & (sum[W-1] ^ a[W-1]);
      else        flag_v = ~(a[W-1] ^ b[W-1]) & (sum[W-1] ^ a[W-1]);
   end

   always_comb begin
      if (!$isunknown({a, b, op}) && op == OP_SUB)
         AST_BORROW_IS_LESS: assert (flag_c == (a < b)); // R3
   end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 22
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   op,
   output logic [W-1:0] res
);

   localparam int PAD_W = W - IMM_W;

   logic [W-1:0] pass_val;

   generate
      if (PAD_W == 0) begin : g_pass_full
         assign pass_val = b;
      end else begin : g_pass_hi
         assign pass_val = {b[IMM_W-1:0], {PAD_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_ANDN: res = a & ~b;
         OP_ORN:  res = a | ~b;
         OP_XNOR: res = ~(a ^ b);
         OP_PASS: res = pass_val;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu_longpath.sv
module alu_longpath
   import alu_pkg::*;
#(
   parameter int W         = 32,
   parameter int TID_W     = 6,
   parameter bit MUL_SPLIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [3:0]       op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [W-1:0]     y_in,
   input  logic [TID_W-1:0] tid_in,
   output logic             pend,
   output logic [W-1:0]     lo,
   output logic [W-1:0]     hi,
   output logic             y_wr,
   output logic [TID_W-1:0] ret_tid
);

   localparam int SH_W = $clog2(W);
   localparam int H    = W / 2;
   localparam int W2   = 2 * W;

   logic [SH_W-1:0]  shamt;
   logic [W-1:0]     shift_res;
   logic             is_mul;
   logic             is_signed;

   logic             s1_mul;
   logic [TID_W-1:0] s1_tid;
   logic [W-1:0]     s1_y;
   logic [W-1:0]     s1_shift;
   logic [W2-1:0]    prod;

   assign shamt     = b[SH_W-1:0];
   assign is_mul    = op_is_mul(op);
   assign is_signed = (op == OP_SMUL);

   always_comb begin
      unique case (op)
         OP_SLL:  shift_res = a << shamt;
         OP_SRL:  shift_res = a >> shamt;
         OP_SRA:  shift_res = W'($signed(a) >>> shamt);
         default: shift_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= issue;
   end

   always_ff @(posedge clk) begin
      if (issue) begin
         s1_mul   <= is_mul;
         s1_tid   <= tid_in;
         s1_y     <= y_in;
         s1_shift <= shift_res;
      end
   end

   generate
      if (MUL_SPLIT) begin : g_mul_split
         // stage 1: four half-width partial products plus a sign correction
         logic [W-1:0] pp_ll, pp_lh, pp_hl, pp_hh, corr;
         logic [W-1:0] corr_n;
         always_comb begin
            corr_n = '0;
            if (is_signed) begin
               if (a[W-1]) corr_n = corr_n + b;
               if (b[W-1]) corr_n = corr_n + a;
            end
         end
         always_ff @(posedge clk) begin
            if (issue) begin
               pp_ll <= a[H-1:0] * b[H-1:0];
               pp_lh <= a[H-1:0] * b[W-1:H];
               pp_hl <= a[W-1:H] * b[H-1:0];
               pp_hh <= a[W-1:H] * b[W-1:H];
               corr  <= corr_n;
            end
         end
         // stage 2: combine, then correct the high word for signed operands
         logic [W2-1:0] usum;
         always_comb begin
            usum = {{W{1'b0}}, pp_ll}
                 + ({{W{1'b0}}, pp_lh} << H)
                 + ({{W{1'b0}}, pp_hl} << H)
                 + {pp_hh, {W{1'b0}}};
            prod = {usum[W2-1:W] - corr, usum[W-1:0]};
         end
      end else begin : g_mul_whole
         logic [W2-1:0] prod_q;
         logic [W2-1:0] ext_a, ext_b;
         always_comb begin
            ext_a = is_signed ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
            ext_b = is_signed ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
         end
         always_ff @(posedge clk) begin
            if (issue) prod_q <= W2'(ext_a * ext_b);
         end
         assign prod = prod_q;
      end
   endgenerate

   assign lo      = s1_mul ? prod[W-1:0] : s1_shift;
   assign hi      = s1_mul ? prod[W2-1:W] : s1_y;
   assign y_wr    = s1_mul;
   assign ret_tid = s1_tid;

endmodule

// File: rtl/split_alu.sv
module split_alu
   import alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int TID_W     = 6,
   parameter int IMM_W     = 22,
   parameter bit MUL_SPLIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic              in_cin,
   input  logic [DATA_W-1:0] in_y,
   input  logic [TID_W-1:0]  in_tid,
   output logic              issue_conflict,
   output logic              out_valid,
   output logic [TID_W-1:0]  out_tid,
   output logic [DATA_W-1:0] out_result,
   output logic [DATA_W-1:0] out_y,
   output logic              out_y_wr,
   output logic              out_n,
   output logic              out_z,
   output logic              out_v,
   output logic              out_c
);

   generate
      if (DATA_W % 2 != 0)     begin : g_chk_even  $error("DATA_W must be even"); end
      if (IMM_W > DATA_W)      begin : g_chk_imm   $error("IMM_W exceeds DATA_W"); end
      if (TID_W < 1)           begin : g_chk_tid   $error("TID_W must be positive"); end
      if (DATA_W < 4)          begin : g_chk_width $error("DATA_W too small"); end
   endgenerate

   logic              op_long;
   logic              fast_issue;
   logic              long_issue;
   logic [DATA_W-1:0] add_sum, logic_res, fast_res;
   logic              add_v, add_c, fast_v, fast_c;
   logic              long_pend, long_ywr;
   logic [DATA_W-1:0] long_lo, long_hi;
   logic [TID_W-1:0]  long_tid;
   logic [DATA_W-1:0] ret_res;

   assign op_long    = op_is_long(in_op);
   assign long_issue = in_valid & op_long;
   assign fast_issue = in_valid & ~op_long;

   alu_addsub #(.W(DATA_W)) u_addsub (
      .a(in_a), .b(in_b), .op(in_op), .cin(in_cin),
      .sum(add_sum), .flag_v(add_v), .flag_c(add_c)
   );

   alu_logic #(.W(DATA_W), .IMM_W(IMM_W)) u_logic (
      .a(in_a), .b(in_b), .op(in_op), .res(logic_res)
   );

   alu_longpath #(.W(DATA_W), .TID_W(TID_W), .MUL_SPLIT(MUL_SPLIT)) u_long (
      .clk(clk), .rst_n(rst_n), .issue(long_issue), .op(in_op),
      .a(in_a), .b(in_b), .y_in(in_y), .tid_in(in_tid),
      .pend(long_pend), .lo(long_lo), .hi(long_hi),
      .y_wr(long_ywr), .ret_tid(long_tid)
   );

   always_comb begin
      if (op_is_arith(in_op)) begin
         fast_res = add_sum;
         fast_v   = add_v;
         fast_c   = add_c;
      end else begin
         fast_res = logic_res;
         fast_v   = 1'b0;
         fast_c   = 1'b0;
      end
   end

   // a single-cycle op issued now would share the retire slot with the op in flight
   assign issue_conflict = fast_issue & long_pend;

   assign ret_res = long_pend ? long_lo : fast_res;

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= long_pend | fast_issue;
   end

   always_ff @(posedge clk) begin
      out_result <= ret_res;
      out_n      <= ret_res[DATA_W-1];
      out_z      <= (ret_res == '0);
      if (long_pend) begin
         out_tid  <= long_tid;
         out_y    <= long_hi;
         out_y_wr <= long_ywr;
         out_v    <= 1'b0;
         out_c    <= 1'b0;
      end else begin
         out_tid  <= in_tid;
         out_y    <= in_y;
         out_y_wr <= 1'b0;
         out_v    <= fast_v;
         out_c    <= fast_c;
      end
   end

   AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_issue && !issue_conflict) |=> (out_valid && out_tid == $past(in_tid) && !out_y_wr)); // R1
   AST_LONG_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      long_issue |=> ##1 (out_valid && out_tid == $past(in_tid, 2))); // R10
   AST_CONFLICT_LONG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      issue_conflict |=> (out_valid && out_tid == $past(in_tid, 2))); // R11
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_z == (out_result == '0) && out_n == out_result[DATA_W-1])); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !long_pend) |=> !out_valid); // R12
   AST_LONG_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_y_wr) |-> (!out_v && !out_c)); // R8

endmodule

// File: tb/split_alu_tb.sv
module split_alu_tb;

   typedef struct packed {
      logic        v;
      logic [5:0]  tid;
      logic [31:0] r;
      logic [31:0] y;
      logic        yw;
      logic        n, z, fv, fc;
      logic [3:0]  op;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_op = '0;
   logic [31:0] in_a = '0, in_b = '0, in_y = '0;
   logic        in_cin = 1'b0;
   logic [5:0]  in_tid = '0;
   logic        issue_conflict, out_valid, out_y_wr, out_n, out_z, out_v, out_c;
   logic [5:0]  out_tid;
   logic [31:0] out_result, out_y;

   int checks = 0;
   int errors = 0;
   exp_t cur_exp = '0;
   exp_t pend_exp = '0;

   always #2.5 clk = ~clk;

   split_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .in_y(in_y), .in_tid(in_tid),
      .issue_conflict(issue_conflict), .out_valid(out_valid), .out_tid(out_tid),
      .out_result(out_result), .out_y(out_y), .out_y_wr(out_y_wr),
      .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
   );

   function automatic exp_t model(input logic [3:0] op, input logic [31:0] a, b,
                                  input logic cin, input logic [31:0] y, input logic [5:0] tid);
      exp_t e;
      logic [32:0] w;
      logic [63:0] p;
      e = '0; e.v = 1'b1; e.tid = tid; e.y = y; e.op = op;
      case (op)
         4'd0: begin w = {1'b0,a} + {1'b0,b}; e.r = w[31:0]; e.fc = w[32];
                  e.fv = (a[31] == b[31]) && (e.r[31] != a[31]); end
         4'd1: begin w = {1'b0,a} + {1'b0,b} + {32'd0,cin}; e.r = w[31:0]; e.fc = w[32];
                  e.fv = (a[31] == b[31]) && (e.r[31] != a[31]); end
         4'd2: begin e.r = a - b; e.fc = a < b;
                  e.fv = (a[31] != b[31]) && (e.r[31] != a[31]); end
         4'd3: begin e.r = a - b - {31'd0,cin}; e.fc = ({1'b0,a} < ({1'b0,b} + {32'd0,cin}));
                  e.fv = (a[31] != b[31]) && (e.r[31] != a[31]); end
         4'd4: e.r = a & b;
         4'd5: e.r = a | b;
         4'd6: e.r = a ^ b;
         4'd7: e.r = a & ~b;
         4'd8: e.r = a | ~b;
         4'd9: e.r = ~(a ^ b);
         4'd10: e.r = {b[21:0], 10'd0};
         4'd11: e.r = a << b[4:0];
         4'd12: e.r = a >> b[4:0];
         4'd13: e.r = $signed(a) >>> b[4:0];
         4'd14: begin p = {32'd0,a} * {32'd0,b}; e.r = p[31:0]; e.y = p[63:32]; e.yw = 1'b1; end
         default: begin p = {{32{a[31]}},a} * {{32{b[31]}},b}; e.r = p[31:0]; e.y = p[63:32]; e.yw = 1'b1; end
      endcase
      e.n = e.r[31];
      e.z = (e.r == 32'd0);
      return e;
   endfunction

   function automatic string res_tag(input logic [3:0] op);
      if (op <= 4'd3) return "R1";
      if (op <= 4'd9) return "R4";
      if (op == 4'd10) return "R5";
      if (op <= 4'd13) return "R7";
      return "R8";
   endfunction

   function automatic string flag_tag(input logic [3:0] op);
      if (op <= 4'd1) return "R2";
      if (op <= 4'd3) return "R3";
      return "R6";
   endfunction

   task automatic check(input string tag, input string what, input logic [63:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      string vt;
      vt = (cur_exp.v && cur_exp.op >= 4'd11) ? "R10" : "R12";
      check(vt, "out_valid", 64'(out_valid), 64'(cur_exp.v));
      if (cur_exp.v) begin
         check(vt, "out_tid", 64'(out_tid), 64'(cur_exp.tid));
         check(res_tag(cur_exp.op), "out_result", 64'(out_result), 64'(cur_exp.r));
         check(cur_exp.yw ? "R8" : "R9", "out_y/out_y_wr", {31'd0, out_y_wr, out_y},
               {31'd0, cur_exp.yw, cur_exp.y});
         check(flag_tag(cur_exp.op), "flags nzvc", 64'({out_n, out_z, out_v, out_c}),
               64'({cur_exp.n, cur_exp.z, cur_exp.fv, cur_exp.fc}));
      end
   endtask

   // called at a falling edge: check what retired, drive the next issue
   task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a, b,
                       input logic cin, input logic [31:0] y, input logic [5:0] tid);
      exp_t e, nxt;
      logic is_long;
      check_outputs();
      in_valid = v; in_op = op; in_a = a; in_b = b; in_cin = cin; in_y = y; in_tid = tid;
      #1;
      is_long = (op >= 4'd11);
      e = model(op, a, b, cin, y, tid);
      check("R11", "issue_conflict", 64'(issue_conflict), 64'(v && !is_long && pend_exp.v));
      if (pend_exp.v)          nxt = pend_exp;
      else if (v && !is_long)  nxt = e;
      else                     nxt = '0;
      pend_exp = (v && is_long) ? e : '0;
      cur_exp = nxt;
      @(negedge clk);
   endtask

   task automatic idle();
      step(1'b0, 4'd0, 32'd0, 32'd0, 1'b0, 32'd0, 6'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R12 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      check("R12", "out_valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      step(1, 4'd0, 32'h7fffffff, 32'd1, 0, 32'h11, 6'd1);         // R2 overflow
      step(1, 4'd0, 32'hffffffff, 32'd1, 0, 32'h12, 6'd2);         // R2 carry, zero
      step(1, 4'd1, 32'hfffffffe, 32'd1, 1, 32'h13, 6'd3);         // R2 addx carry in
      step(1, 4'd2, 32'd0, 32'd1, 0, 32'h14, 6'd4);                // R3 borrow
      step(1, 4'd3, 32'd5, 32'd5, 1, 32'h15, 6'd5);                // R3 subx borrow in
      step(1, 4'd3, 32'd5, 32'd4, 1, 32'h16, 6'd6);                // R3 subx equal
      step(1, 4'd2, 32'h80000000, 32'd1, 0, 32'h17, 6'd7);         // R3 overflow
      step(1, 4'd10, 32'hdeadbeef, 32'hffc12345, 0, 32'h18, 6'd8); // R5
      step(1, 4'd7, 32'hf0f0f0f0, 32'hff00ff00, 0, 32'h19, 6'd9);  // R4
      step(1, 4'd9, 32'h12345678, 32'h12345678, 0, 32'h1a, 6'd10); // R4, R6 all ones
      step(1, 4'd13, 32'h80000010, 32'hffffffe4, 0, 32'h1b, 6'd11);// R7 amount 4 only
      idle();
      step(1, 4'd15, 32'hffffffff, 32'hffffffff, 0, 32'h1c, 6'd12);// R8 -1*-1
      step(1, 4'd15, 32'h80000000, 32'h80000000, 0, 32'h1d, 6'd13);// R8, R10 back to back
      step(1, 4'd14, 32'hffffffff, 32'hffffffff, 0, 32'h1e, 6'd14);// R8 unsigned
      step(1, 4'd0, 32'd3, 32'd4, 0, 32'h1f, 6'd15);               // R11 conflict, dropped
      idle();
      step(1, 4'd11, 32'd1, 32'd31, 0, 32'h20, 6'd16);             // R7
      idle();
      idle();
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [3:0] op;
         logic [31:0] a, b;
         op = 4'($urandom_range(0, 15));
         a = $urandom();
         b = $urandom();
         if ($urandom_range(0, 7) == 0) b = a;
         if ($urandom_range(0, 7) == 0) a = 32'h80000000;
         step($urandom_range(0, 9) != 0, op, a, b, 1'($urandom_range(0, 1)),
              $urandom(), 6'($urandom_range(0, 63)));
      end
      idle();
      idle();
      idle();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule